// File: doc/BRIEF.md
# Skip-Value Synchronous Counter

This block is a synchronous up-counter that walks through the full range of its count width but never shows any nonzero value that is a multiple of a fixed stride. With the default 4-bit width and a stride of 4, the values 4, 8 and 12 never appear. The counter does not use a modulus wrap to remove these values. A small decoder watches the current count and recognises the value just below each value to be removed. On that cycle it raises a load strobe and presents a jump target two above the current count. The counter core takes that target on the next rising clock edge.

The core follows a fixed synchronous priority: clear, then load, then count, then hold. All of its actions take effect only on a rising edge. The clear input is active-low and also serves as the block's reset. A single count enable gates both loading and counting. While the enable is low the count holds, even when the decoder matches. The load strobe is a combinational observation output. It reflects the current count in every cycle, whatever the enable does. The decoder drives its jump target to zero in cycles where it does not match.

Top module: `skip_counter`

## Requirements
- R1: With clr_n high and en high, from count 0 the count visits 0,1,2,3,5,6,7,9,10,11,13,14,15 in that order, one value per rising edge, and then repeats from 0.
- R2: load_strobe is 1 in exactly the cycles where count is 3, 7 or 11, and 0 for every other count value. It follows count within the same cycle, whatever en is.
- R3: When en is high and count is 3, 7 or 11, the next rising edge loads 5, 9 or 13 respectively.
- R4: When clr_n is 0 at a rising edge, count becomes 0 after that edge, whatever en or load_strobe are. The clear overrides both loading and counting.
- R5: When clr_n is 1 and en is 0 at a rising edge, count keeps its value, and no load happens even while load_strobe is 1.
- R6: When en is high and count is 15, load_strobe is 0 and the next edge makes count 0 by natural wrap.
- R7: count never takes the value 4, 8 or 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous active-low clear; also the block reset |
| en | input | 1 | Count enable; gates both counting and jump loads |
| count | output | 4 | Current counter value |
| load_strobe | output | 1 | High while the count sits on a value that precedes a removed value |

## Verification
count is registered, so every change caused by clr_n or en shows up one rising edge after the inputs are applied. load_strobe is combinational from count, so it is due in the same cycle as the count value it describes. The bench changes its inputs one time unit after a rising edge and compares count and load_strobe at that point. Each comparison therefore sees the result of exactly one edge since the previous stimulus. The stimulus covers two full laps, holds with the strobe active, and clears issued in mid-sequence.

// File: rtl/skip_counter_pkg.sv
// Package: skip_counter_pkg
// Shared defaults and the action type for the skip-value counter.
// Assumes the stride is a power of two of at least 2.
package skip_counter_pkg;

    localparam int unsigned CNT_WIDTH_DEF   = 4;
    localparam int unsigned SKIP_STRIDE_DEF = 4;

    // Action chosen by the counter core for the coming edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_action_e;

endpackage

// File: rtl/skip_decode.sv
// Module: skip_decode
// Recognises a count one below a value to be removed (a nonzero multiple of
// STRIDE) and supplies the jump target, which is two above the count.
// The all-ones value wraps to zero naturally, so it is never matched.
// Assumes STRIDE is a power of two, at least 2, and not larger than 2**WIDTH.
module skip_decode #(
    parameter int unsigned WIDTH  = skip_counter_pkg::CNT_WIDTH_DEF,
    parameter int unsigned STRIDE = skip_counter_pkg::SKIP_STRIDE_DEF
) (
    input  logic [WIDTH-1:0] cnt,
    output logic             hit,
    output logic [WIDTH-1:0] jump_val
);

    localparam int unsigned     LOW_BITS = $clog2(STRIDE);
    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] STEP2   = WIDTH'(2);

    logic low_all_ones;

    // Low bits all ones means the next value is a multiple of the stride.
    assign low_all_ones = &cnt[LOW_BITS-1:0];

    // Match and jump target; the target is zero when there is no match.
    always_comb begin
        hit      = low_all_ones && (cnt != MAX_VAL);
        jump_val = hit ? (cnt + STEP2) : '0;
    end

endmodule

// File: rtl/skip_counter_core.sv
// Module: skip_counter_core
// Synchronous counter with priority clear > load > count > hold.
// The clear is active-low and acts only on a rising edge. The load and the
// count both need en.
module skip_counter_core #(
    parameter int unsigned WIDTH = skip_counter_pkg::CNT_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             en,
    input  logic             ld_req,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] q
);

    import skip_counter_pkg::*;

    localparam logic [WIDTH-1:0] STEP1 = WIDTH'(1);

    cnt_action_e action;

    // Choose the action for the coming edge by fixed priority.
    always_comb begin
        if (!clr_n)
            action = ACT_CLEAR;
        else if (en && ld_req)
            action = ACT_LOAD;
        else if (en)
            action = ACT_COUNT;
        else
            action = ACT_HOLD;
    end

    // Apply the chosen action to the count register.
    always_ff @(posedge clk) begin
        case (action)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= ld_val;
            ACT_COUNT: q <= q + STEP1;
            default:   q <= q;
        endcase
    end

    // R4: a low clear at an edge leaves zero, whatever else is requested.
    assert_clear_wins_R4: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R5: with the enable low, the value holds even if a load is requested.
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!clr_n)
        !en |=> $stable(q));

    // R3: an enabled load request takes the offered value on the next edge.
    assert_load_taken_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (en && ld_req) |=> (q == $past(ld_val)));

endmodule

// File: rtl/skip_counter.sv
// Module: skip_counter
// Top level: a counter that skips the nonzero multiples of STRIDE. It does
// this by decoding the preceding value and loading past the removed one.
// clr_n is the synchronous active-low clear and also the reset.
module skip_counter #(
    parameter int unsigned WIDTH  = skip_counter_pkg::CNT_WIDTH_DEF,
    parameter int unsigned STRIDE = skip_counter_pkg::SKIP_STRIDE_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             en,
    output logic [WIDTH-1:0] count,
    output logic             load_strobe
);

    localparam int unsigned      LOW_BITS = $clog2(STRIDE);
    localparam logic [WIDTH-1:0] MAX_VAL  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] STEP1    = WIDTH'(1);

    logic             dec_hit;
    logic [WIDTH-1:0] dec_target;
    logic [WIDTH-1:0] q_int;

    // Decoder: spots the value just before a removed one.
    skip_decode #(
        .WIDTH  (WIDTH),
        .STRIDE (STRIDE)
    ) u_decode (
        .cnt      (q_int),
        .hit      (dec_hit),
        .jump_val (dec_target)
    );

    // Core: holds the count and applies clear, load or increment.
    skip_counter_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .en     (en),
        .ld_req (dec_hit),
        .ld_val (dec_target),
        .q      (q_int)
    );

    // Drive the outputs from the core and the decoder.
    assign count       = q_int;
    assign load_strobe = dec_hit;

    // R7: the count never rests on a nonzero multiple of the stride.
    assert_no_removed_value_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (count[LOW_BITS-1:0] != '0) || (count == '0));

    // R6: the all-ones value wraps to zero with no load.
    assert_wrap_at_top_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (en && count == MAX_VAL) |=> (count == '0));

    // R1: without a strobe, an enabled edge advances the count by one.
    assert_plain_step_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (en && !load_strobe) |=> (count == $past(count) + STEP1));

endmodule

// File: tb/skip_counter_test.sv
// Bench for skip_counter: a table walk over two laps, then directed cases.
module skip_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int SEQ_LEN    = 13;
    // Each entry is {expected strobe, expected count}.
    localparam logic [4:0] SEQ_TBL [SEQ_LEN] = '{
        5'h00, 5'h01, 5'h02, 5'h13, 5'h05, 5'h06, 5'h17,
        5'h09, 5'h0A, 5'h1B, 5'h0D, 5'h0E, 5'h0F
    };

    logic       clk = 1'b0;
    logic       clr_n;
    logic       en;
    logic [3:0] count;
    logic       load_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    skip_counter uut (
        .clk         (clk),
        .clr_n       (clr_n),
        .en          (en),
        .count       (count),
        .load_strobe (load_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one observed value against its expectation.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for one rising edge, then move away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Print the summary once and end the run.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        finish_run();
    end

    initial begin
        clr_n = 1'b0;
        en    = 1'b0;
        step();
        step();
        // R4: the reset state is zero with no strobe.
        chk("R4 reset count", count, 0);
        chk("R2 reset strobe", load_strobe, 0);

        clr_n = 1'b1;
        en    = 1'b1;
        // R1 R2 R3 R6 R7: walk two full laps from the table.
        for (int i = 0; i < 2 * SEQ_LEN; i++) begin
            chk("R1 sequence count", count, SEQ_TBL[i % SEQ_LEN][3:0]);
            chk("R2 sequence strobe", load_strobe, SEQ_TBL[i % SEQ_LEN][4]);
            step();
        end
        chk("R6 wrap back to zero", count, 0);

        // R4: a clear while sitting on 3 beats the pending load.
        step(); step(); step();
        chk("R2 strobe at 3", load_strobe, 1);
        clr_n = 1'b0;
        step();
        chk("R4 clear beats load", count, 0);
        clr_n = 1'b1;

        // R5: hold at 7 with the strobe active.
        repeat (6) step();
        chk("R3 reach 7", count, 7);
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R5 hold at 7", count, 7);
            chk("R2 strobe while held", load_strobe, 1);
        end
        en = 1'b1;
        step();
        chk("R3 load 9 after hold", count, 9);

        // R4: a clear beats counting at 9.
        clr_n = 1'b0;
        step();
        chk("R4 clear beats count", count, 0);
        clr_n = 1'b1;

        // R3: from 11 the jump goes to 13; R6: at 15 there is no strobe.
        repeat (9) step();
        chk("R3 reach 11", count, 11);
        step();
        chk("R3 load 13", count, 13);
        chk("R7 strobe off at 13", load_strobe, 0);
        step(); step();
        chk("R6 at 15", count, 15);
        chk("R6 strobe off at 15", load_strobe, 0);
        en = 1'b0;
        step();
        chk("R5 hold at 15", count, 15);
        en = 1'b1;
        step();
        chk("R6 wrap to 0", count, 0);

        finish_run();
    end

endmodule